// File: doc/BRIEF.md
# Bit-select logic shift unit

This unit executes eight single-bit logic-and-shift instructions against a file of sixteen 32-bit data registers. Each cycle it may take one 32-bit instruction word, qualified by a valid strobe. The word names two source registers, one bit position inside each of them, a destination register and a logic function.

The unit takes the two chosen bits and combines them with the chosen function. It then shifts the destination register left by one place, so the old top bit is lost. The one-bit result goes into bit 0. A separate write port loads register values, and a combinational read port returns any register for inspection.

A word whose primary opcode is not one of the two that the unit knows changes no register. Such a word raises an illegal-instruction flag for one cycle. The unit has no status flags, so no flag changes when an instruction runs.

Top module: `sbls_unit`

## Requirements
- R1: While rst_ni is low, all 16 registers are cleared to zero. The clear is asynchronous.
- R2: A load with wr_en_i high writes wr_data_i into register wr_addr_i at the next rising edge. rd_data_o always shows register rd_addr_i combinationally.
- R3: The instruction fields are: destination index in bits 31..28, second bit position in 27..23, secondary opcode in 22..21, first bit position in 20..16, second source index in 15..12, first source index in 11..8, and primary opcode in 7..0. Operand a is bit pos1 of the first source. Operand b is bit pos2 of the second source. Both positions cover 0 to 31.
- R4: A legal instruction accepted at a rising edge replaces the destination with {old[30:0], result} at that same edge. Old bit 31 is dropped.
- R5: Primary opcode 0x27 selects a function by secondary opcode: 0 gives a AND b, 1 gives a OR b, 2 gives NOT(a OR b), 3 gives a AND NOT b.
- R6: Primary opcode 0xA7 selects a function by secondary opcode: 0 gives NOT(a AND b), 1 gives a OR NOT b, 2 gives NOT(a XOR b), 3 gives a XOR b.
- R7: All operands are read before write-back. When the destination is also a source, the selected bit comes from the value before the shift.
- R8: A valid word with any other primary opcode leaves every register unchanged. It drives illegal_o high for exactly the one cycle that follows the accepting edge. illegal_o is low at all other times.
- R9: When a load and a legal instruction target the same register at the same edge, the loaded value wins. When they target different registers, both writes take effect.
- R10: With instr_valid_i and wr_en_i both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| wr_en_i | input | 1 | Load strobe for the write port |
| wr_addr_i | input | 4 | Register index to load |
| wr_data_i | input | 32 | Value to load |
| rd_addr_i | input | 4 | Register index to read |
| rd_data_o | output | 32 | Value of register rd_addr_i |
| illegal_o | output | 1 | One-cycle pulse after an illegal word |

## Verification
Several properties are checked on every cycle:
- After each legal instruction, the upper 31 bits of the destination equal the old lower 31 bits (R4).
- The illegal flag follows exactly the words with a bad primary opcode (R8).
- Those words leave the register file untouched (R8).
- A load always lands, even when an instruction targets the same register (R9).
- With both strobes idle, the file stays stable (R10).

The bench scenarios cover what the properties cannot. They show the exact bit computed for each of the eight functions, over random positions and register values (R5, R6). They show that the field positions are decoded as specified (R3), that a destination which is also a source reads its value from before the shift (R7), and the reset contents (R1).

// File: rtl/sbls_pkg.sv
package sbls_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 16;
  localparam int unsigned REG_AW = $clog2(NREG);
  localparam int unsigned POS_W  = $clog2(XLEN);

  localparam logic [7:0] PRI_POS = 8'h27;
  localparam logic [7:0] PRI_NEG = 8'hA7;

  // order matches {pri[7], sec}
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NOR  = 3'd2,
    OP_ANDN = 3'd3,
    OP_NAND = 3'd4,
    OP_ORN  = 3'd5,
    OP_XNOR = 3'd6,
    OP_XOR  = 3'd7
  } bit_op_e;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [POS_W-1:0]  pos_b;
    logic [1:0]        sec;
    logic [POS_W-1:0]  pos_a;
    logic [REG_AW-1:0] src_b;
    logic [REG_AW-1:0] src_a;
    logic [7:0]        pri;
  } insn_t;
endpackage

// File: rtl/sbls_decode.sv
module sbls_decode
  import sbls_pkg::*;
(
  input  logic [31:0]       instr_i,
  input  logic              valid_i,
  output logic [REG_AW-1:0] dst_o,
  output logic [REG_AW-1:0] src_a_o,
  output logic [REG_AW-1:0] src_b_o,
  output logic [POS_W-1:0]  pos_a_o,
  output logic [POS_W-1:0]  pos_b_o,
  output bit_op_e           op_o,
  output logic              exec_o,
  output logic              illegal_o
);
  insn_t insn;
  logic  known;

  assign insn    = insn_t'(instr_i);
  assign dst_o   = insn.dst;
  assign src_a_o = insn.src_a;
  assign src_b_o = insn.src_b;
  assign pos_a_o = insn.pos_a;
  assign pos_b_o = insn.pos_b;

  always_comb begin
    known = (insn.pri == PRI_POS) || (insn.pri == PRI_NEG);
    op_o  = bit_op_e'({insn.pri[7], insn.sec});
  end

  assign exec_o    = valid_i &  known;
  assign illegal_o = valid_i & ~known;
endmodule

// File: rtl/sbls_bit_alu.sv
module sbls_bit_alu
  import sbls_pkg::*;
#(
  parameter int unsigned W = XLEN,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic [PW-1:0] pos_a_i,
  input  logic [PW-1:0] pos_b_i,
  input  bit_op_e       op_i,
  input  logic [W-1:0]  dst_i,
  output logic [W-1:0]  dst_o
);
  logic a, b, r;

  assign a = op_a_i[pos_a_i];
  assign b = op_b_i[pos_b_i];

  always_comb begin
    unique case (op_i)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_NOR:  r = ~(a | b);
      OP_ANDN: r = a & ~b;
      OP_NAND: r = ~(a & b);
      OP_ORN:  r = a | ~b;
      OP_XNOR: r = ~(a ^ b);
      OP_XOR:  r = a ^ b;
      default: r = 1'b0;
    endcase
  end

  assign dst_o = {dst_i[W-2:0], r};
endmodule

// File: rtl/sbls_regfile.sv
module sbls_regfile
  import sbls_pkg::*;
#(
  parameter int unsigned N = NREG,
  parameter int unsigned W = XLEN,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_en_i,
  input  logic [AW-1:0]       ld_addr_i,
  input  logic [W-1:0]        ld_data_i,
  input  logic                ex_en_i,
  input  logic [AW-1:0]       ex_addr_i,
  input  logic [W-1:0]        ex_data_i,
  input  logic [AW-1:0]       ra_i,
  input  logic [AW-1:0]       rb_i,
  input  logic [AW-1:0]       rd_i,
  input  logic [AW-1:0]       rx_i,
  output logic [W-1:0]        ra_o,
  output logic [W-1:0]        rb_o,
  output logic [W-1:0]        rd_o,
  output logic [W-1:0]        rx_o,
  output logic [N-1:0][W-1:0] regs_o
);
  logic [N-1:0][W-1:0] mem_q;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit_ld, hit_ex;
    assign hit_ld = ld_en_i && (ld_addr_i == AW'(i));
    assign hit_ex = ex_en_i && (ex_addr_i == AW'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mem_q[i] <= '0;
      else if (hit_ld) mem_q[i] <= ld_data_i;  // load port wins
      else if (hit_ex) mem_q[i] <= ex_data_i;
    end
  end

  assign ra_o   = mem_q[ra_i];
  assign rb_o   = mem_q[rb_i];
  assign rd_o   = mem_q[rd_i];
  assign rx_o   = mem_q[rx_i];
  assign regs_o = mem_q;
endmodule

// File: rtl/sbls_unit.sv
module sbls_unit
  import sbls_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        instr_valid_i,
  input  logic [31:0] instr_i,
  input  logic        wr_en_i,
  input  logic [3:0]  wr_addr_i,
  input  logic [31:0] wr_data_i,
  input  logic [3:0]  rd_addr_i,
  output logic [31:0] rd_data_o,
  output logic        illegal_o
);
  logic [REG_AW-1:0] dst, src_a, src_b;
  logic [POS_W-1:0]  pos_a, pos_b;
  bit_op_e           op;
  logic              exec, illegal;
  logic [XLEN-1:0]   val_a, val_b, val_d, val_n;
  logic [NREG-1:0][XLEN-1:0] regs;
  logic              illegal_q;

  sbls_decode u_dec (
    .instr_i   (instr_i),
    .valid_i   (instr_valid_i),
    .dst_o     (dst),
    .src_a_o   (src_a),
    .src_b_o   (src_b),
    .pos_a_o   (pos_a),
    .pos_b_o   (pos_b),
    .op_o      (op),
    .exec_o    (exec),
    .illegal_o (illegal)
  );

  sbls_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_en_i   (wr_en_i),
    .ld_addr_i (wr_addr_i),
    .ld_data_i (wr_data_i),
    .ex_en_i   (exec),
    .ex_addr_i (dst),
    .ex_data_i (val_n),
    .ra_i      (src_a),
    .rb_i      (src_b),
    .rd_i      (dst),
    .rx_i      (rd_addr_i),
    .ra_o      (val_a),
    .rb_o      (val_b),
    .rd_o      (val_d),
    .rx_o      (rd_data_o),
    .regs_o    (regs)
  );

  sbls_bit_alu #(.W(XLEN)) u_alu (
    .op_a_i  (val_a),
    .op_b_i  (val_b),
    .pos_a_i (pos_a),
    .pos_b_i (pos_b),
    .op_i    (op),
    .dst_i   (val_d),
    .dst_o   (val_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= illegal;
  end

  assign illegal_o = illegal_q;
endmodule

// File: rtl/sbls_unit_chk.sv
module sbls_unit_chk (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_valid_i,
  input logic [31:0]       instr_i,
  input logic              wr_en_i,
  input logic [3:0]        wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic              illegal_o,
  input logic [15:0][31:0] regs
);
  logic        known;
  logic [3:0]  dst;
  logic [31:0] dst_old;
  logic        collide;

  assign known   = (instr_i[7:0] == 8'h27) || (instr_i[7:0] == 8'hA7);
  assign dst     = instr_i[31:28];
  assign dst_old = regs[dst];
  assign collide = wr_en_i && (wr_addr_i == dst);

  // R4
  shift_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && known && !collide) |=> regs[$past(dst)][31:1] == $past(dst_old[30:0]));

  // R8
  illegal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !known) |=> illegal_o);

  // R8
  illegal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(instr_valid_i && !known));

  // R8
  illegal_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !known && !wr_en_i) |=> $stable(regs));

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs[$past(wr_addr_i)] == $past(wr_data_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_valid_i && !wr_en_i) |=> $stable(regs));
endmodule

bind sbls_unit sbls_unit_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_i       (instr_i),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .illegal_o     (illegal_o),
  .regs          (regs)
);

// File: tb/sbls_unit_test.sv
`timescale 1ns/1ps
module sbls_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [16];
  int unsigned seed_dummy;

  sbls_unit uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    finish_run();
  end

  function automatic logic [31:0] mk(input logic [7:0] pri, input logic [1:0] sec,
                                     input logic [3:0] d, input logic [3:0] a, input logic [4:0] pa,
                                     input logic [3:0] b, input logic [4:0] pb);
    return {d, pb, sec, pa, b, a, pri};   // R3 field layout
  endfunction

  function automatic logic fbit(input logic [7:0] pri, input logic [1:0] sec,
                                input logic a, input logic b);
    if (pri == 8'h27) begin  // R5
      case (sec)
        2'd0: return a & b;
        2'd1: return a | b;
        2'd2: return ~(a | b);
        default: return a & ~b;
      endcase
    end else begin           // R6
      case (sec)
        2'd0: return ~(a & b);
        2'd1: return a | ~b;
        2'd2: return ~(a ^ b);
        default: return a ^ b;
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input string tag, input int idx);
    rd_addr_i = idx[3:0];
    #1;
    check(tag, rd_data_o, model[idx]);
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = idx[3:0]; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model[idx] = v;
  endtask

  // update model for a word; returns whether legal
  function automatic logic apply(input logic [31:0] w);
    logic [7:0] pri;
    logic r;
    pri = w[7:0];
    if (pri != 8'h27 && pri != 8'hA7) return 1'b0;
    r = fbit(pri, w[22:21], model[w[11:8]][w[20:16]], model[w[15:12]][w[27:23]]);
    model[w[31:28]] = {model[w[31:28]][30:0], r};
    return 1'b1;
  endfunction

  task automatic exec(input string tag, input logic [31:0] w);
    logic legal;
    @(negedge clk_i);
    instr_valid_i = 1'b1; instr_i = w;
    legal = apply(w);
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    check({tag, " illegal_o"}, {31'b0, illegal_o}, {31'b0, ~legal});
    check_reg(tag, int'(w[31:28]));
  endtask

  initial begin
    logic [31:0] w;
    seed_dummy = $urandom(32'd2024);
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int i = 0; i < 16; i++) check_reg("R1 reset", i);
    check("R1 illegal_o reset", {31'b0, illegal_o}, 32'b0);

    // R2 loads
    for (int i = 0; i < 16; i++) load(i, $urandom);
    for (int i = 0; i < 16; i++) check_reg("R2 load", i);

    // R3 R5 R6: every function, every operand combination, at corner positions
    for (int f = 0; f < 8; f++) begin
      for (int ab = 0; ab < 4; ab++) begin
        load(1, ab[1] ? 32'h8000_0001 : 32'h0);
        load(2, ab[0] ? 32'h8000_0001 : 32'h0);
        w = mk(f[2] ? 8'hA7 : 8'h27, f[1:0], 4'd3, 4'd1, (ab == 1) ? 5'd31 : 5'd0,
               4'd2, (ab == 2) ? 5'd0 : 5'd31);
        exec(f[2] ? "R6 function" : "R5 function", w);
      end
    end

    // R4 top bit dropped
    load(5, 32'hFFFF_FFFF);
    exec("R4 shift drop", mk(8'h27, 2'd1, 4'd5, 4'd0, 5'd0, 4'd0, 5'd0));

    // R7 destination equals source a, bit 31 read before shift
    load(6, 32'h8000_0000);
    exec("R7 dst as src", mk(8'hA7, 2'd3, 4'd6, 4'd6, 5'd31, 4'd7, 5'd0));
    load(8, 32'h4000_0000);
    exec("R7 dst as both", mk(8'h27, 2'd0, 4'd8, 4'd8, 5'd30, 4'd8, 5'd30));

    // R8 illegal word
    load(9, 32'hDEAD_BEEF);
    exec("R8 illegal", mk(8'h26, 2'd1, 4'd9, 4'd9, 5'd3, 4'd9, 5'd4));
    @(negedge clk_i);
    check("R8 pulse width", {31'b0, illegal_o}, 32'b0);
    for (int i = 0; i < 16; i++) check_reg("R8 no write", i);

    // R9 collision and disjoint writes
    load(10, 32'h1234_5678);
    @(negedge clk_i);
    instr_valid_i = 1'b1; instr_i = mk(8'hA7, 2'd1, 4'd10, 4'd0, 5'd0, 4'd0, 5'd0);
    wr_en_i = 1'b1; wr_addr_i = 4'd10; wr_data_i = 32'hCAFE_F00D;
    @(negedge clk_i);
    instr_valid_i = 1'b0; wr_en_i = 1'b0;
    model[10] = 32'hCAFE_F00D;
    check_reg("R9 load wins", 10);
    @(negedge clk_i);
    w = mk(8'h27, 2'd1, 4'd11, 4'd12, 5'd7, 4'd13, 5'd9);
    instr_valid_i = 1'b1; instr_i = w;
    void'(apply(w));
    wr_en_i = 1'b1; wr_addr_i = 4'd14; wr_data_i = 32'h0BAD_CAFE;
    @(negedge clk_i);
    instr_valid_i = 1'b0; wr_en_i = 1'b0;
    model[14] = 32'h0BAD_CAFE;
    check_reg("R9 disjoint instr", 11);
    check_reg("R9 disjoint load", 14);

    // R10 idle with junk on buses
    @(negedge clk_i);
    instr_i = 32'hFFFF_FFA7; wr_data_i = 32'h5555_5555; wr_addr_i = 4'd0;
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < 16; i++) check_reg("R10 idle", i);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] pri;
      int s;
      s = $urandom_range(0, 9);
      pri = (s < 4) ? 8'h27 : (s < 8) ? 8'hA7 : 8'($urandom);
      if ($urandom_range(0, 7) == 0) load($urandom_range(0, 15), $urandom);
      w = $urandom;
      w[7:0] = pri;
      exec((pri == 8'h27) ? "R5 random" : (pri == 8'hA7) ? "R6 random" : "R8 random", w);
    end
    for (int i = 0; i < 16; i++) check_reg("R4 final", i);

    finish_run();
  end
endmodule